// File: doc/BRIEF.md
# Video DMA line address generator

This block keeps track of where each incoming video line is written in memory by a write DMA channel. It holds a line counter and a line start address. A frame start pulse reloads the address from a programmed base and clears the counter. Each later line start strobe moves both forward according to the selected layout: a plain stride, one of two interleaved skip layouts, or a ring of lines that returns to the base after a programmed number of lines.

The stride is given in 16-byte units. The ring length is an 8-bit size scaled by a granularity of 1, 4 or 64 lines. Some configuration combinations are illegal. For those, the block raises an error flag and steps like the plain stride layout, so the address stays predictable. The DMA engine reads the two registered outputs at each line start.

Top module: `vdma_line_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, with no strobe seen yet, `line_num` and `line_addr` are 0.
- R2: A cycle with `frame_start` high loads `line_num` = 0 and `line_addr` = `cfg_base_addr` at the next clock edge, even if `line_tag` is also high in that cycle.
- R3: In a cycle with neither `frame_start` nor `line_tag`, both outputs keep their values.
- R4: With `cfg_circ_sel` = 0 and `cfg_pattern` = 0, each `line_tag` adds 1 to `line_num` and `cfg_stride`×16 to `line_addr`. The address wraps modulo 2^32 and the line number wraps modulo 2^14.
- R5: With `cfg_circ_sel` = 0 and `cfg_pattern` = 2 (write two, skip two), a tag adds 1 line and 1 stride when `line_num` is even. When it is odd, the tag adds 3 lines and 3 strides.
- R6: With `cfg_circ_sel` = 0 and `cfg_pattern` = 3 (write two, skip four), a tag adds 1 line and 1 stride when `line_num` is even. When it is odd, the tag adds 5 lines and 5 strides.
- R7: With `cfg_circ_sel` = 0 and `cfg_pattern` = 1, the block steps exactly as in R4.
- R8: With `cfg_circ_sel` = 1, 2 or 3, the granularity G is 1, 4 or 64. When a tag arrives and `line_num` equals G×`cfg_circ_size`, `line_num` returns to 0 and `line_addr` to `cfg_base_addr`. Otherwise the tag adds 1 line and 1 stride.
- R9: `cfg_err` is high, combinationally, exactly when `cfg_circ_sel` ≠ 0 and either `cfg_pattern` ≠ 0 or `cfg_addr_mode` is neither 0 nor 4.
- R10: While `cfg_err` is high, each tag steps as in R4, with no skip and no wrap.
- R11: In a legal ring mode with `cfg_circ_size` = 0, every tag returns the outputs to line 0 and the base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base_addr | input | 32 | Byte address of line 0 |
| cfg_stride | input | 15 | Line stride in 16-byte units |
| cfg_circ_sel | input | 2 | 0 off, 1/2/3 ring with G = 1/4/64 |
| cfg_circ_size | input | 8 | Ring size in units of G lines |
| cfg_pattern | input | 2 | 0/1 linear, 2 write2-skip2, 3 write2-skip4 |
| cfg_addr_mode | input | 3 | Channel address mode; 0 and 4 legal with ring |
| frame_start | input | 1 | Frame start pulse, reloads the base |
| line_tag | input | 1 | Line start strobe |
| line_num | output | 14 | Current line number |
| line_addr | output | 32 | Current line start address |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
The step assertions take the configuration sampled in the same cycle as the strobe that uses it. They assume nothing about how long the configuration stays unchanged. The skip-layout parity checks are only meaningful when the line number starts from an even value. For that reason, the stimulus changes configuration on a falling edge and follows each change with a frame start before any tags. Ring wrap checks compare the counter against the limit derived from the configuration present at the tag. Each ring scenario runs enough tags to pass the limit at least once.

// File: rtl/vlag_pkg.sv
package vlag_pkg;

    typedef enum logic [1:0] {
        RING_OFF = 2'd0,
        RING_G1  = 2'd1,
        RING_G4  = 2'd2,
        RING_G64 = 2'd3
    } ring_sel_e;

    typedef enum logic [1:0] {
        LAY_LINEAR   = 2'd0,
        LAY_LINEAR_B = 2'd1,
        LAY_SKIP2    = 2'd2,
        LAY_SKIP4    = 2'd3
    } layout_e;

    localparam int unsigned GRAN_SHIFT_MAX = 6;
    localparam int unsigned MULT_W         = 3;

    // log2 of the ring granularity for each selector value
    function automatic int unsigned gran_shift(input logic [1:0] sel);
        case (sel)
            2'd2:    return 2;
            2'd3:    return 6;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/vlag_cfg_check.sv
module vlag_cfg_check (
    input  logic [1:0] circ_sel,
    input  logic [1:0] pattern,
    input  logic [2:0] addr_mode,
    output logic       cfg_err,
    output logic       ring_on,
    output logic       skip_on,
    output logic       skip_wide
);
    import vlag_pkg::*;

    logic ring_req;
    logic mode_ok;

    always_comb begin
        ring_req  = (circ_sel != RING_OFF);
        mode_ok   = (addr_mode == 3'd0) || (addr_mode == 3'd4);
        cfg_err   = ring_req && ((pattern != LAY_LINEAR) || !mode_ok);
        ring_on   = ring_req && !cfg_err;
        skip_on   = !ring_req && pattern[1];
        skip_wide = (pattern == LAY_SKIP4);
    end

endmodule

// File: rtl/vlag_ring_limit.sv
module vlag_ring_limit #(
    parameter int unsigned SIZE_W = 8,
    parameter int unsigned LN_W   = 14
) (
    input  logic [1:0]        circ_sel,
    input  logic [SIZE_W-1:0] circ_size,
    output logic [LN_W-1:0]   limit
);
    import vlag_pkg::*;

    localparam int unsigned LIM_W = SIZE_W + GRAN_SHIFT_MAX;

    logic [LIM_W-1:0] scaled;

    always_comb begin
        scaled = LIM_W'(circ_size) << gran_shift(circ_sel);
        limit  = LN_W'(scaled);
    end

endmodule

// File: rtl/vlag_step_calc.sv
module vlag_step_calc #(
    parameter int unsigned ADDR_W       = 32,
    parameter int unsigned STRIDE_W     = 15,
    parameter int unsigned STRIDE_SHIFT = 4,
    parameter int unsigned MULT_W       = 3
) (
    input  logic [STRIDE_W-1:0] stride,
    input  logic [MULT_W-1:0]   mult,
    output logic [ADDR_W-1:0]   delta
);
    logic [ADDR_W-1:0] stride_bytes;
    logic [ADDR_W-1:0] acc [MULT_W+1];

    assign stride_bytes = ADDR_W'(stride) << STRIDE_SHIFT;
    assign acc[0]       = '0;

    // shift-and-add over the bits of the small multiplier
    for (genvar b = 0; b < MULT_W; b++) begin : g_term
        assign acc[b+1] = acc[b] + (mult[b] ? (stride_bytes << b) : '0);
    end

    assign delta = acc[MULT_W];

endmodule

// File: rtl/vdma_line_addr_gen.sv
module vdma_line_addr_gen #(
    parameter int unsigned ADDR_W       = 32,
    parameter int unsigned STRIDE_W     = 15,
    parameter int unsigned STRIDE_SHIFT = 4,
    parameter int unsigned SIZE_W       = 8,
    parameter int unsigned LN_W         = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   cfg_base_addr,
    input  logic [STRIDE_W-1:0] cfg_stride,
    input  logic [1:0]          cfg_circ_sel,
    input  logic [SIZE_W-1:0]   cfg_circ_size,
    input  logic [1:0]          cfg_pattern,
    input  logic [2:0]          cfg_addr_mode,
    input  logic                frame_start,
    input  logic                line_tag,
    output logic [LN_W-1:0]     line_num,
    output logic [ADDR_W-1:0]   line_addr,
    output logic                cfg_err
);
    import vlag_pkg::*;

    typedef struct packed {
        logic [LN_W-1:0]   num;
        logic [ADDR_W-1:0] addr;
    } line_state_t;

    line_state_t       st_d, st_q;
    logic              ring_on, skip_on, skip_wide;
    logic [LN_W-1:0]   ring_limit;
    logic [MULT_W-1:0] step_mult;
    logic [ADDR_W-1:0] addr_delta;
    logic              at_limit;

    vlag_cfg_check u_cfg (
        .circ_sel  (cfg_circ_sel),
        .pattern   (cfg_pattern),
        .addr_mode (cfg_addr_mode),
        .cfg_err   (cfg_err),
        .ring_on   (ring_on),
        .skip_on   (skip_on),
        .skip_wide (skip_wide)
    );

    vlag_ring_limit #(.SIZE_W(SIZE_W), .LN_W(LN_W)) u_limit (
        .circ_sel  (cfg_circ_sel),
        .circ_size (cfg_circ_size),
        .limit     (ring_limit)
    );

    vlag_step_calc #(
        .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W),
        .STRIDE_SHIFT(STRIDE_SHIFT), .MULT_W(MULT_W)
    ) u_step (
        .stride (cfg_stride),
        .mult   (step_mult),
        .delta  (addr_delta)
    );

    always_comb begin
        step_mult = MULT_W'(1);
        if (skip_on && st_q.num[0]) begin
            step_mult = skip_wide ? MULT_W'(5) : MULT_W'(3);
        end
        at_limit = (st_q.num == ring_limit);

        st_d = st_q;
        if (frame_start) begin
            st_d.num  = '0;
            st_d.addr = cfg_base_addr;
        end else if (line_tag) begin
            if (ring_on && at_limit) begin
                st_d.num  = '0;
                st_d.addr = cfg_base_addr;
            end else begin
                st_d.num  = st_q.num + LN_W'(step_mult);
                st_d.addr = st_q.addr + addr_delta;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_num  = st_q.num;
    assign line_addr = st_q.addr;

    // R2
    frame_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (line_num == '0) && (line_addr == $past(cfg_base_addr)));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !line_tag) |=> $stable(line_num) && $stable(line_addr));

    // R4
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && line_tag && cfg_circ_sel == 2'd0 && cfg_pattern == 2'd0)
        |=> (line_num == $past(line_num) + LN_W'(1)) &&
            (line_addr == $past(line_addr) + (ADDR_W'($past(cfg_stride)) << STRIDE_SHIFT)));

    // R5
    skip_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && line_tag && cfg_circ_sel == 2'd0 && cfg_pattern[1] && !line_num[0])
        |=> line_num == $past(line_num) + LN_W'(1));

    // R6
    skip_wide_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && line_tag && cfg_circ_sel == 2'd0 && cfg_pattern == 2'd3 && line_num[0])
        |=> line_num == $past(line_num) + LN_W'(5));

    // R8
    ring_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && line_tag && !cfg_err && cfg_circ_sel != 2'd0 &&
         line_num == LN_W'({cfg_circ_size, 6'b0} >> (6 - gran_shift(cfg_circ_sel))))
        |=> (line_num == '0) && (line_addr == $past(cfg_base_addr)));

    // R10
    err_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && line_tag && cfg_err)
        |=> line_num == $past(line_num) + LN_W'(1));

endmodule

// File: tb/vdma_line_addr_gen_tb.sv
module vdma_line_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_base_addr = '0;
    logic [14:0] cfg_stride = '0;
    logic [1:0]  cfg_circ_sel = '0;
    logic [7:0]  cfg_circ_size = '0;
    logic [1:0]  cfg_pattern = '0;
    logic [2:0]  cfg_addr_mode = '0;
    logic        frame_start = 1'b0;
    logic        line_tag = 1'b0;
    logic [13:0] line_num;
    logic [31:0] line_addr;
    logic        cfg_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    vdma_line_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_base_addr(cfg_base_addr), .cfg_stride(cfg_stride),
        .cfg_circ_sel(cfg_circ_sel), .cfg_circ_size(cfg_circ_size),
        .cfg_pattern(cfg_pattern), .cfg_addr_mode(cfg_addr_mode),
        .frame_start(frame_start), .line_tag(line_tag),
        .line_num(line_num), .line_addr(line_addr), .cfg_err(cfg_err)
    );

    // behavioural reference
    int          m_num = 0;
    bit [31:0]   m_addr = '0;
    string       m_req = "R1";

    function automatic bit model_err();
        return (cfg_circ_sel != 0) &&
               ((cfg_pattern != 0) || !(cfg_addr_mode == 0 || cfg_addr_mode == 4));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_num = 0; m_addr = '0; m_req = "R1";
        end else if (frame_start) begin
            m_num = 0; m_addr = cfg_base_addr; m_req = "R2";
        end else if (line_tag) begin
            int lines;
            int gran;
            lines = 1;
            if (model_err()) begin
                m_req = "R10";
            end else if (cfg_circ_sel != 0) begin
                gran  = (cfg_circ_sel == 1) ? 1 : (cfg_circ_sel == 2) ? 4 : 64;
                m_req = (cfg_circ_size == 0) ? "R11" : "R8";
                if (m_num == gran * cfg_circ_size) lines = 0;
            end else if (cfg_pattern == 2) begin
                m_req = "R5";
                if (m_num % 2 == 1) lines = 3;
            end else if (cfg_pattern == 3) begin
                m_req = "R6";
                if (m_num % 2 == 1) lines = 5;
            end else begin
                m_req = (cfg_pattern == 1) ? "R7" : "R4";
            end
            if (lines == 0) begin
                m_num = 0; m_addr = cfg_base_addr;
            end else begin
                m_num  = (m_num + lines) % 16384;
                m_addr = m_addr + 32'(lines * 16 * int'(cfg_stride));
            end
        end else if (m_req != "R1") begin
            m_req = "R3";
        end
    end

    // compare every cycle, 2 ns after the rising edge
    always begin
        @(posedge clk);
        #2;
        if (!done) begin
            checks++;
            if (line_num !== 14'(m_num) || line_addr !== m_addr) begin
                fails++;
                $display("FAIL %s: num=%0d addr=%h expected num=%0d addr=%h",
                         m_req, line_num, line_addr, m_num, m_addr);
            end
            checks++;
            if (cfg_err !== model_err()) begin
                fails++;
                $display("FAIL R9: cfg_err=%0b expected %0b", cfg_err, model_err());
            end
        end
    end

    task automatic step(input bit fs, input bit tag);
        @(negedge clk);
        frame_start = fs;
        line_tag    = tag;
    endtask

    task automatic tags(input int n);
        for (int i = 0; i < n; i++) begin
            step(1'b0, 1'b1);
            if (i % 4 == 3) step(1'b0, 1'b0);
        end
        step(1'b0, 1'b0);
    endtask

    task automatic setup(input logic [31:0] base, input logic [14:0] stride,
                         input logic [1:0] csel, input logic [7:0] csize,
                         input logic [1:0] pat, input logic [2:0] amode);
        @(negedge clk);
        cfg_base_addr = base; cfg_stride = stride; cfg_circ_sel = csel;
        cfg_circ_size = csize; cfg_pattern = pat; cfg_addr_mode = amode;
        frame_start = 1'b1; line_tag = 1'b0;
        step(1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset values observed while in reset
        #2;
        checks++;
        if (line_num !== '0 || line_addr !== '0) begin
            fails++;
            $display("FAIL R1: num=%0d addr=%h expected 0 0", line_num, line_addr);
        end
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);

        setup(32'h0000_1000, 15'd5, 2'd0, 8'd0, 2'd0, 3'd0);   // R4
        tags(7);
        setup(32'hFFFF_FF00, 15'h7FFF, 2'd0, 8'd0, 2'd0, 3'd2); // R4 wrap
        tags(3);
        setup(32'h0010_0000, 15'd3, 2'd0, 8'd0, 2'd2, 3'd0);    // R5
        tags(9);
        setup(32'h0020_0000, 15'd7, 2'd0, 8'd0, 2'd3, 3'd0);    // R6
        tags(9);
        setup(32'h0030_0000, 15'd2, 2'd0, 8'd0, 2'd1, 3'd0);    // R7
        tags(5);
        setup(32'h0040_0000, 15'd4, 2'd1, 8'd3, 2'd0, 3'd0);    // R8 G=1
        tags(10);
        setup(32'h0050_0000, 15'd1, 2'd2, 8'd2, 2'd0, 3'd4);    // R8 G=4
        tags(20);
        setup(32'h0060_0000, 15'd9, 2'd3, 8'd1, 2'd0, 3'd4);    // R8 G=64
        tags(70);
        setup(32'h0070_0000, 15'd6, 2'd1, 8'd0, 2'd0, 3'd0);    // R11
        tags(4);
        setup(32'h0080_0000, 15'd2, 2'd1, 8'd1, 2'd2, 3'd0);    // R9 R10 pattern
        tags(5);
        setup(32'h0090_0000, 15'd2, 2'd2, 8'd1, 2'd0, 3'd2);    // R9 R10 address mode
        tags(8);
        setup(32'h00A0_0000, 15'd2, 2'd0, 8'd0, 2'd3, 3'd5);    // R9: no error without ring
        tags(3);

        // R2: frame start wins over a simultaneous tag
        setup(32'h00B0_0000, 15'd8, 2'd0, 8'd0, 2'd0, 3'd0);
        tags(3);
        step(1'b1, 1'b1);
        step(1'b0, 1'b0);
        tags(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule